// File: doc/BRIEF.md
# Dual-Format Audio Serial Receiver

This block takes in a three-wire stereo audio link: a bit clock, a frame (word-select) clock and one serial data line. It turns the serial stream back into two parallel 24-bit two's-complement words, left and right. One static format input chooses between two framings:

- **Left-justified:** the most significant bit arrives on the first bit-clock rising edge after a frame-clock change.
- **I2S:** the most significant bit arrives one bit clock later.

Bits after the 24th in a half-frame carry nothing and are dropped. This lets the same logic accept 48fs, 64fs or any bit-clock rate in between.

The block runs directly on the bit clock. It finds frame boundaries by comparing successive samples of the frame clock. When a right word finishes, it presents the pair on its outputs together with a one-cycle strobe. The pair is issued only if a left word was captured since the previous strobe. A downstream filter or sample FIFO can therefore latch both channels on that strobe.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is asserted (rstN low) and after its release, leftOut and rightOut read zero and sampleStb is low until the first stereo pair completes.
- R2: With fmtI2s low (left-justified), the first data bit of a half-frame is the one sampled at the first rising sclk edge on which the new frameClk level is seen; the half with frameClk high carries the left channel.
- R3: With fmtI2s high (I2S), the first data bit of a half-frame is sampled one rising sclk edge after the new frameClk level is first seen; the half with frameClk low carries the left channel.
- R4: Each channel word is 24 bits, sent most significant bit first, and is presented unchanged, including the extremes 0x800000, 0x7FFFFF, 0x000000 and 0xFFFFFF.
- R5: Serial bits that follow the 24th data bit of a half-frame have no effect on either output word (bit clock above 48fs, for example 64fs).
- R6: At exactly 48fs (24 bit clocks per half) both formats decode correctly, including I2S where the right channel's last bit is sampled on the first edge of the following half.
- R7: sampleStb is high for exactly one sclk cycle, beginning at the rising edge that samples the last bit of a right word. leftOut and rightOut change together at that edge and hold their values in every other cycle.
- R8: A right word that completes with no left word captured since the previous strobe produces no strobe and leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial bit clock; all state advances on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| fmtI2s | input | 1 | Framing select: 0 left-justified, 1 I2S; static during operation |
| frameClk | input | 1 | Frame (word-select) clock |
| serData | input | 1 | Serial audio data |
| leftOut | output | 24 | Left channel word of the latest pair |
| rightOut | output | 24 | Right channel word of the latest pair |
| sampleStb | output | 1 | One-cycle pulse marking a new stereo pair |

## Verification
Several properties are checked on every cycle:
- the strobe lasting a single cycle;
- the output words holding still between strobes;
- the bit position never leaving its saturating range;
- channel completions being spaced at least a cycle apart;
- each strobe being preceded by a right-word completion.

Whether the words carry the right bits, and whether each format picks the right half for each channel, can only be shown by the bench. It sends random and extreme words in both framings at 48fs and 64fs and predicts the exact strobe cycle. The same holds for trailing bits being dropped and for a lone right half being suppressed.

// File: rtl/audrx_pkg.sv
package audrx_pkg;

  // Per-cycle commands from the framing control to the word datapath.
  typedef struct packed {
    logic shiftEn;    // current serial bit belongs to a data word
    logic leftDone;   // current bit is the last bit of a left word
    logic rightDone;  // current bit is the last bit of a right word
  } rxStrobes_t;

endpackage

// File: rtl/audrx_ctrl.sv
module audrx_ctrl
  import audrx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic       sclk,
  input  logic       rstN,
  input  logic       fmtI2s,
  input  logic       frameClk,
  output rxStrobes_t strb
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [1:0]       frHist;    // [0] previous frame sample, [1] the one before
  logic [1:0]       fillHist;  // marks which history entries hold real samples
  logic [CNT_W-1:0] cnt;       // position of the next bit, saturates at CNT_IDLE
  logic [CNT_W-1:0] bitIdx;
  logic             effCur;
  logic             effPrev;
  logic             effOk;
  logic             frameEdge;
  logic             isRight;
  logic             lastBit;

  // I2S is handled as left-justified framing seen through a frame clock
  // delayed by one bit clock, so one counter serves both formats.
  always_comb begin
    if (fmtI2s) begin
      effCur  = frHist[0];
      effPrev = frHist[1];
      effOk   = fillHist[1];
    end else begin
      effCur  = frameClk;
      effPrev = frHist[0];
      effOk   = fillHist[0];
    end
    frameEdge = effOk && (effCur != effPrev);
    bitIdx    = frameEdge ? '0 : cnt;
    lastBit   = (bitIdx == CNT_LAST);
    isRight   = fmtI2s ? effCur : ~effCur;
    strb.shiftEn   = (bitIdx < CNT_IDLE);
    strb.leftDone  = lastBit && !isRight;
    strb.rightDone = lastBit && isRight;
  end

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      frHist   <= '0;
      fillHist <= '0;
      cnt      <= CNT_IDLE;
    end else begin
      frHist   <= {frHist[0], frameClk};
      fillHist <= {fillHist[0], 1'b1};
      if (frameEdge) begin
        cnt <= CNT_ONE;
      end else if (cnt != CNT_IDLE) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge sclk) disable iff (!rstN)
    cnt <= CNT_IDLE);  // R5

  AST_DONE_SPACING: assert property (@(posedge sclk) disable iff (!rstN)
    (strb.leftDone || strb.rightDone) |=> !(strb.leftDone || strb.rightDone));  // R6

endmodule

// File: rtl/audrx_datapath.sv
module audrx_datapath
  import audrx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              sclk,
  input  logic              rstN,
  input  logic              serData,
  input  rxStrobes_t        strb,
  output logic [WORD_W-1:0] leftOut,
  output logic [WORD_W-1:0] rightOut,
  output logic              sampleStb
);

  logic [WORD_W-2:0] shiftReg;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] leftHold;
  logic              leftPend;

  // The word completes with the bit arriving this cycle.
  assign word = {shiftReg, serData};

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      leftHold  <= '0;
      leftPend  <= 1'b0;
      leftOut   <= '0;
      rightOut  <= '0;
      sampleStb <= 1'b0;
    end else begin
      sampleStb <= 1'b0;
      if (strb.shiftEn) begin
        shiftReg <= word[WORD_W-2:0];
      end
      if (strb.leftDone) begin
        leftHold <= word;
        leftPend <= 1'b1;
      end
      if (strb.rightDone && leftPend) begin
        leftOut   <= leftHold;
        rightOut  <= word;
        sampleStb <= 1'b1;
        leftPend  <= 1'b0;
      end
    end
  end

  AST_STB_SINGLE: assert property (@(posedge sclk) disable iff (!rstN)
    sampleStb |=> !sampleStb);  // R7

  AST_OUT_HOLD: assert property (@(posedge sclk) disable iff (!rstN)
    !sampleStb |-> ($stable(leftOut) && $stable(rightOut)));  // R7

  AST_STB_AFTER_RIGHT: assert property (@(posedge sclk) disable iff (!rstN)
    $rose(sampleStb) |-> $past(strb.rightDone));  // R8

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import audrx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              sclk,
  input  logic              rstN,
  input  logic              fmtI2s,
  input  logic              frameClk,
  input  logic              serData,
  output logic [WORD_W-1:0] leftOut,
  output logic [WORD_W-1:0] rightOut,
  output logic              sampleStb
);

  rxStrobes_t strb;

  audrx_ctrl #(.WORD_W(WORD_W)) uCtrl (
    .sclk     (sclk),
    .rstN     (rstN),
    .fmtI2s   (fmtI2s),
    .frameClk (frameClk),
    .strb     (strb)
  );

  audrx_datapath #(.WORD_W(WORD_W)) uData (
    .sclk      (sclk),
    .rstN      (rstN),
    .serData   (serData),
    .strb      (strb),
    .leftOut   (leftOut),
    .rightOut  (rightOut),
    .sampleStb (sampleStb)
  );

endmodule

// File: tb/tb_audio_serial_rx.sv
module tb_audio_serial_rx;

  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         fmtI2s = 1'b0;
  logic         frameClk = 1'b0;
  logic         serData = 1'b0;
  logic [W-1:0] leftOut;
  logic [W-1:0] rightOut;
  logic         sampleStb;

  int unsigned  cyc = 0;
  int           checks = 0;
  int           fails = 0;
  bit           finished = 1'b0;
  bit           monEn = 1'b0;
  bit           prevStb = 1'b0;
  int           bph = 32;
  logic [W-1:0] lastWord = '0;

  logic [W-1:0]  expL[$];
  logic [W-1:0]  expR[$];
  int unsigned   expC[$];

  audio_serial_rx #(.WORD_W(W)) dut (
    .sclk(clk), .rstN(rstN), .fmtI2s(fmtI2s), .frameClk(frameClk),
    .serData(serData), .leftOut(leftOut), .rightOut(rightOut), .sampleStb(sampleStb)
  );

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  // Level of frameClk during the left half: high for left-justified (R2), low for I2S (R3).
  function automatic logic leftLevel(input logic i2s);
    return i2s ? 1'b0 : 1'b1;
  endfunction

  // Serial bit for slot s of a half carrying w; prev is the previous half's word.
  // Slots past the data are filled with random don't-care bits (R5).
  function automatic logic slotBit(input logic i2s, input int s, input int perHalf,
                                   input logic [W-1:0] w, input logic [W-1:0] prev);
    int k;
    k = s - (i2s ? 1 : 0);
    if (k < 0) begin
      if (perHalf == W) return prev[0];  // R6: I2S LSB spills into next half
      return 1'($urandom);
    end
    if (k < W) return w[W-1-k];
    return 1'($urandom);
  endfunction

  function automatic string fmtTag(input logic i2s);
    return i2s ? "R3" : "R2";
  endfunction

  task automatic sendHalf(input logic lvl, input logic [W-1:0] w, output int unsigned firstCyc);
    for (int s = 0; s < bph; s++) begin
      @(negedge clk);
      if (s == 0) firstCyc = cyc + 1;
      frameClk = lvl;
      serData  = slotBit(fmtI2s, s, bph, w, lastWord);
    end
    lastWord = w;
  endtask

  task automatic sendFrame(input logic [W-1:0] l, input logic [W-1:0] r);
    int unsigned p0;
    int unsigned pDummy;
    sendHalf(leftLevel(fmtI2s), l, p0);
    // Strobe edge: last right bit, one slot later in I2S (R7).
    expL.push_back(l);
    expR.push_back(r);
    expC.push_back(p0 + 32'(bph) + 32'(W - 1) + (fmtI2s ? 32'd1 : 32'd0));
    sendHalf(~leftLevel(fmtI2s), r, pDummy);
  endtask

  task automatic doCheck(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runCase(input logic i2s, input int perHalf, input int frames);
    int unsigned dummy;
    logic [W-1:0] l;
    logic [W-1:0] r;
    @(negedge clk);
    monEn  = 1'b0;
    rstN   = 1'b0;
    fmtI2s = i2s;
    bph    = perHalf;
    frameClk = leftLevel(i2s);
    repeat (3) @(negedge clk);
    doCheck(leftOut == '0 && rightOut == '0 && sampleStb == 1'b0, "R1", "reset outputs",
            {40'd0, leftOut ^ rightOut}, 64'd0);
    rstN  = 1'b1;
    monEn = 1'b1;
    repeat (4) @(negedge clk);
    // Lone right half with no left before it: no strobe may follow (R8).
    sendHalf(~leftLevel(i2s), W'($urandom), dummy);
    for (int f = 0; f < frames; f++) begin
      case (f)
        0: begin l = 24'h800000; r = 24'h7FFFFF; end  // R4 extremes
        1: begin l = 24'h000000; r = 24'hFFFFFF; end
        2: begin l = 24'h7FFFFF; r = 24'h800000; end
        3: begin l = 24'hA5A5A5; r = 24'h5A5A5A; end
        default: begin l = W'($urandom); r = W'($urandom); end
      endcase
      sendFrame(l, r);
    end
    // Trailing half so the I2S right LSB has its slot.
    sendHalf(leftLevel(i2s), W'($urandom), dummy);
    repeat (4) @(negedge clk);
    doCheck(expL.size() == 0, fmtTag(i2s), "pairs left unstrobed", 64'(expL.size()), 64'd0);
    expL.delete(); expR.delete(); expC.delete();
  endtask

  // Monitor: every strobe is compared against the predicted pair and cycle.
  always @(negedge clk) begin
    if (monEn) begin
      if (sampleStb && prevStb) doCheck(1'b0, "R7", "strobe wider than one cycle", 64'd1, 64'd0);
      if (sampleStb) begin
        if (expL.size() == 0) begin
          doCheck(1'b0, "R8", "unexpected strobe", 64'(cyc), 64'd0);
        end else begin
          doCheck(leftOut == expL[0], bph == W ? "R6" : "R5", "left word",
                  64'(leftOut), 64'(expL[0]));
          doCheck(rightOut == expR[0], "R4", "right word", 64'(rightOut), 64'(expR[0]));
          doCheck(cyc == expC[0], "R7", "strobe cycle", 64'(cyc), 64'(expC[0]));
          void'(expL.pop_front()); void'(expR.pop_front()); void'(expC.pop_front());
        end
      end
    end
    prevStb = sampleStb;
  end

  initial begin
    void'($urandom(32'd20250611));
    runCase(1'b0, 32, 24);  // R2 + R5
    runCase(1'b0, 24, 24);  // R2 + R6
    runCase(1'b1, 32, 24);  // R3 + R5
    runCase(1'b1, 24, 24);  // R3 + R6
    runCase(1'b1, 27, 12);
    runCase(1'b0, 29, 12);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule